// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block walks an SD memory card from power-on to a selected, 4-bit-bus data state. It does this by issuing commands through a command-issue interface and reacting to the answers. For each step it presents a command index, a 32-bit argument and the response length it expects. The command path, which is outside this block, answers with either a completion strobe plus the response bits or a no-response strobe. The sequencer also asks a clock unit to stop the card clock and to restart it at the identification rate or at the data-transfer rate.

A one-cycle `start` pulse begins the flow, and another pulse at any time restarts it. The flow runs through clock setup, reset and interface check, then the repeated application operating-condition handshake, then identification, addressing, capacity read-out, the switch to the fast clock, selection, the optional block-length command and the bus-width change. It ends with a one-cycle `done` pulse. On success `ok` is high and the card's relative address, operating-condition word, high-capacity flag and size in 512-byte blocks are held on the outputs. On failure `err_code` gives the cause.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, `busy`, `done`, `ok` and `cmd_valid` are 0, and `err_code` is 0 (no failure). While `busy` is 0, no command or clock strobe is issued.
- R2: On `start`, a clock stop strobe is issued first if `clk_running` is 1. Then `clk_set` is issued with `clk_sel`=0 (400 kHz), and the block waits for `clk_stable`. After that it issues command 0 with argument 0 and response kind 0 (none), then command 8 with argument 0x1AA and response kind 1 (48-bit).
- R3: If command 8 receives no response (`cmd_timeout`, or no answer within POLL_LIMIT cycles), the flow ends with `err_code`=1 (unsupported).
- R4: If the response word `rsp_data[31:0]` to command 8 is not exactly 0x1AA, the flow ends with `err_code`=2 (unusable).
- R5: Each operating-condition attempt is command 55 with argument 0 followed by command 41 with argument 0x50FF8000. If the response to command 41 does not have all of bits 23:15 set, the flow ends with `err_code`=2.
- R6: If response bit 31 of command 41 is 0, or either command of the attempt gets no response, the block waits RETRY_DELAY cycles and starts a new attempt. After ATTEMPT_LIMIT attempts without success, the flow ends with `err_code`=3 (I/O error).
- R7: Any other wait, whether for a command answer or for `clk_stable`, gives up after POLL_LIMIT cycles with `err_code`=3. A `cmd_timeout` on any command other than command 8 and the two operating-condition commands also gives `err_code`=3.
- R8: Once the card reports it is ready, the order is as follows. Command 2 is issued with response kind 2 (136-bit). Command 3 is issued next, and bits 31:16 of its response become `rca`. Command 9 is issued with argument {rca,16'h0}. The clock is then stopped and set again with `clk_sel`=1 (25 MHz). Finally command 7 is issued with argument {rca,16'h0}.
- R9: Command 16 with argument 512 follows command 7 only when bit 30 of the operating-condition word is 0. Otherwise it is skipped, and `high_cap` shows that bit.
- R10: The flow finishes with command 55 (argument {rca,16'h0}) and then command 6 (argument 2). It then pulses `done` with `ok`=1 and `err_code`=0, and `ocr` holds the accepted command-41 response.
- R11: For command 9, `rsp_data` carries register bits 127:8. C_SIZE is taken from `rsp_data[65:54]`, C_SIZE_MULT from `rsp_data[41:39]` and READ_BL_LEN from `rsp_data[75:72]`. `capacity_blocks` = ((C_SIZE+1) << (C_SIZE_MULT+2+READ_BL_LEN)) >> 9.
- R12: A `start` pulse during a run abandons that run and restarts the flow (clock setup, then command 0).
- R13: `cmd_valid`, `clk_stop` and `clk_set` are one-cycle strobes and are never high together. The command fields stay stable in the cycle after `cmd_valid`. `done` lasts one cycle, and `busy` falls only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin or restart the flow |
| cmd_valid | output | 1 | Issue strobe for the command fields |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_kind | output | 2 | Expected response: 0 none, 1 48-bit, 2 136-bit |
| cmd_done | input | 1 | Command answered, `rsp_data` valid |
| cmd_timeout | input | 1 | Command got no response |
| rsp_data | input | 120 | Response bits (48-bit: word in [31:0]; 136-bit: register bits 127:8) |
| clk_running | input | 1 | Card clock currently enabled |
| clk_stable | input | 1 | Card clock settled after a set request |
| clk_stop | output | 1 | Stop the card clock |
| clk_set | output | 1 | Start the card clock at `clk_sel` rate |
| clk_sel | output | 1 | 0: 400 kHz, 1: 25 MHz |
| busy | output | 1 | Flow in progress |
| done | output | 1 | Flow finished (one cycle) |
| ok | output | 1 | Last flow succeeded |
| err_code | output | 2 | 0 none, 1 unsupported, 2 unusable, 3 I/O error |
| rca | output | 16 | Relative card address |
| ocr | output | 32 | Accepted operating-condition word |
| high_cap | output | 1 | Card reported high capacity |
| capacity_blocks | output | CAP_W | Card size in 512-byte blocks |

## Verification
The hardest condition to reach is the exhausted operating-condition loop. Reaching it takes a card that stays powered-down for every attempt while its voltage window stays valid, so that neither the success path nor the unusable path is taken. The bench's card model answers command 41 with bit 31 cleared until a programmable attempt count has passed. It is given a count larger than ATTEMPT_LIMIT, and the bench then counts the command-41 issues before the I/O error. The same model, configured to become ready after two attempts, provides the timing of the retry back-off: the gap between attempts is compared with the direct gap from command 55 to command 41.

// File: rtl/sd_init_pkg.sv
// Shared types and constants for the SD card initialization sequencer.
// Assumes responses arrive with CRC and framing already removed.
package sd_init_pkg;

    localparam int RSP_W = 120;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_48   = 2'd1,
        RSP_136  = 2'd2
    } rsp_kind_t;

    typedef enum logic [1:0] {
        FAIL_NONE     = 2'd0,
        FAIL_UNSUP    = 2'd1,
        FAIL_UNUSABLE = 2'd2,
        FAIL_IO       = 2'd3
    } fail_code_t;

    typedef enum logic [3:0] {
        ST_GO_IDLE,
        ST_IF_COND,
        ST_LOOP_APP,
        ST_OP_COND,
        ST_GET_CID,
        ST_GET_RCA,
        ST_GET_CSD,
        ST_SELECT,
        ST_BLOCKLEN,
        ST_BUS_APP,
        ST_BUS_WIDTH
    } step_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLK_OFF,
        PH_CLK_ON,
        PH_CLK_WAIT,
        PH_ISSUE,
        PH_WAIT,
        PH_BACKOFF
    } phase_t;

    localparam logic [31:0] IF_COND_PATTERN = 32'h0000_01AA;
    localparam logic [31:0] OP_COND_ARG     = 32'h50FF_8000;
    localparam logic [31:0] VOLT_WINDOW     = 32'h00FF_8000;
    localparam logic [31:0] BLOCK_BYTES     = 32'd512;
    localparam logic [31:0] BUS_4BIT_ARG    = 32'd2;

endpackage

// File: rtl/sd_limit_counter.sv
// Saturating up-counter that flags the last of LIMIT counted cycles.
// Assumes LIMIT >= 1; clear has priority over tick.
module sd_limit_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] count;

    // Count ticks since the last clear, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    assign last = (count == TOP);
endmodule

// File: rtl/sd_cmd_table.sv
// Maps a sequencer step to command index, argument and response kind.
// Assumes the RCA is placed in argument bits 31:16 where a command needs it.
module sd_cmd_table
    import sd_init_pkg::*;
(
    input  step_t       step,
    input  logic [15:0] rca,
    output logic [5:0]  index,
    output logic [31:0] arg,
    output rsp_kind_t   kind
);
    logic [31:0] rca_arg;
    assign rca_arg = {rca, 16'h0000};

    // Decode the fields of the command belonging to the current step.
    always_comb begin
        index = 6'd0;
        arg   = '0;
        kind  = RSP_48;
        unique case (step)
            ST_GO_IDLE:   begin index = 6'd0;  kind = RSP_NONE; end
            ST_IF_COND:   begin index = 6'd8;  arg = IF_COND_PATTERN; end
            ST_LOOP_APP:  begin index = 6'd55; end
            ST_OP_COND:   begin index = 6'd41; arg = OP_COND_ARG; end
            ST_GET_CID:   begin index = 6'd2;  kind = RSP_136; end
            ST_GET_RCA:   begin index = 6'd3;  end
            ST_GET_CSD:   begin index = 6'd9;  arg = rca_arg; kind = RSP_136; end
            ST_SELECT:    begin index = 6'd7;  arg = rca_arg; end
            ST_BLOCKLEN:  begin index = 6'd16; arg = BLOCK_BYTES; end
            ST_BUS_APP:   begin index = 6'd55; arg = rca_arg; end
            ST_BUS_WIDTH: begin index = 6'd6;  arg = BUS_4BIT_ARG; end
            default:      begin index = 6'd0;  kind = RSP_NONE; end
        endcase
    end
endmodule

// File: rtl/sd_csd_capacity.sv
// Computes card size in 512-byte blocks from the CSD fields of a 136-bit response.
// Assumes the input holds register bits 127:8 (CRC byte stripped).
module sd_csd_capacity
    import sd_init_pkg::*;
#(
    parameter int CAP_W = 32
) (
    input  logic [RSP_W-1:0] csd,
    output logic [CAP_W-1:0] blocks
);
    localparam int BYTES_W = 64;
    localparam int BLK_SHIFT = 9;

    logic [11:0]        c_size;
    logic [2:0]         c_mult;
    logic [3:0]         bl_len;
    logic [5:0]         shift;
    logic [BYTES_W-1:0] bytes;

    // Extract the fields and form bytes = (C_SIZE+1) * 2^(MULT+2) * 2^BL_LEN.
    always_comb begin
        c_size = csd[65:54];
        c_mult = csd[41:39];
        bl_len = csd[75:72];
        shift  = 6'(c_mult) + 6'd2 + 6'(bl_len);
        bytes  = (BYTES_W'(c_size) + 1'b1) << shift;
        blocks = CAP_W'(bytes >> BLK_SHIFT);
    end
endmodule

// File: rtl/sd_init_seq.sv
// SD card identification and setup sequencer.
// Drives a command-issue port and a card clock request port; assumes the
// command path answers every cmd_valid with at most one cmd_done or cmd_timeout,
// and that the clock unit drops clk_stable in the cycle after clk_stop/clk_set.
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int POLL_LIMIT    = 1000,
    parameter int ATTEMPT_LIMIT = 1000,
    parameter int RETRY_DELAY   = 1000,
    parameter int CAP_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             cmd_valid,
    output logic [5:0]       cmd_index,
    output logic [31:0]      cmd_arg,
    output logic [1:0]       cmd_rsp_kind,
    input  logic             cmd_done,
    input  logic             cmd_timeout,
    input  logic [RSP_W-1:0] rsp_data,
    input  logic             clk_running,
    input  logic             clk_stable,
    output logic             clk_stop,
    output logic             clk_set,
    output logic             clk_sel,
    output logic             busy,
    output logic             done,
    output logic             ok,
    output logic [1:0]       err_code,
    output logic [15:0]      rca,
    output logic [31:0]      ocr,
    output logic             high_cap,
    output logic [CAP_W-1:0] capacity_blocks
);
    phase_t     phase, nxt_phase;
    step_t      step, nxt_step;
    logic       fast_clk;
    rsp_kind_t  kind;
    logic [31:0] rsp_word;
    logic [CAP_W-1:0] cap_calc;

    logic poll_clear, poll_tick, poll_last;
    logic att_tick, att_last;
    logic gap_tick, gap_last;

    logic end_ok, end_fail, retry, go_fast, ld_rca, ld_ocr, ld_cap;
    fail_code_t code;
    logic volt_ok, powered;

    assign rsp_word = rsp_data[31:0];
    assign volt_ok  = (rsp_word & VOLT_WINDOW) == VOLT_WINDOW;
    assign powered  = rsp_word[31];

    sd_cmd_table u_table (
        .step  (step),
        .rca   (rca),
        .index (cmd_index),
        .arg   (cmd_arg),
        .kind  (kind)
    );

    sd_csd_capacity #(.CAP_W(CAP_W)) u_cap (
        .csd    (rsp_data),
        .blocks (cap_calc)
    );

    sd_limit_counter #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk (clk), .rst_n (rst_n), .clear (poll_clear), .tick (poll_tick), .last (poll_last)
    );

    sd_limit_counter #(.LIMIT(ATTEMPT_LIMIT)) u_attempts (
        .clk (clk), .rst_n (rst_n), .clear (start), .tick (att_tick), .last (att_last)
    );

    sd_limit_counter #(.LIMIT(RETRY_DELAY)) u_backoff (
        .clk (clk), .rst_n (rst_n), .clear (retry), .tick (gap_tick), .last (gap_last)
    );

    // Strobes and field outputs decoded from the current phase.
    always_comb begin
        cmd_valid    = (phase == PH_ISSUE);
        clk_stop     = (phase == PH_CLK_OFF);
        clk_set      = (phase == PH_CLK_ON);
        clk_sel      = fast_clk;
        cmd_rsp_kind = kind;
        poll_clear   = (phase == PH_ISSUE) || (phase == PH_CLK_ON);
        poll_tick    = (phase == PH_WAIT && !cmd_done && !cmd_timeout) ||
                       (phase == PH_CLK_WAIT && !clk_stable);
        gap_tick     = (phase == PH_BACKOFF);
        att_tick     = retry;
    end

    // Next-step decision: response checks, retries and flow ordering.
    always_comb begin
        nxt_phase = phase;
        nxt_step  = step;
        end_ok    = 1'b0;
        end_fail  = 1'b0;
        code      = FAIL_NONE;
        retry     = 1'b0;
        go_fast   = 1'b0;
        ld_rca    = 1'b0;
        ld_ocr    = 1'b0;
        ld_cap    = 1'b0;
        unique case (phase)
            PH_CLK_OFF: nxt_phase = PH_CLK_ON;
            PH_CLK_ON:  nxt_phase = PH_CLK_WAIT;
            PH_CLK_WAIT: begin
                if (clk_stable) begin
                    nxt_phase = PH_ISSUE;
                    nxt_step  = fast_clk ? ST_SELECT : ST_GO_IDLE;
                end else if (poll_last) begin
                    end_fail = 1'b1;
                    code     = FAIL_IO;
                end
            end
            PH_ISSUE: nxt_phase = PH_WAIT;
            PH_WAIT: begin
                if (cmd_done) begin
                    nxt_phase = PH_ISSUE;
                    unique case (step)
                        ST_GO_IDLE: nxt_step = ST_IF_COND;
                        ST_IF_COND: begin
                            if (rsp_word == IF_COND_PATTERN) nxt_step = ST_LOOP_APP;
                            else begin end_fail = 1'b1; code = FAIL_UNUSABLE; end
                        end
                        ST_LOOP_APP: nxt_step = ST_OP_COND;
                        ST_OP_COND: begin
                            if (!volt_ok) begin
                                end_fail = 1'b1;
                                code     = FAIL_UNUSABLE;
                            end else if (powered) begin
                                ld_ocr   = 1'b1;
                                nxt_step = ST_GET_CID;
                            end else begin
                                retry = 1'b1;
                            end
                        end
                        ST_GET_CID: nxt_step = ST_GET_RCA;
                        ST_GET_RCA: begin ld_rca = 1'b1; nxt_step = ST_GET_CSD; end
                        ST_GET_CSD: begin
                            ld_cap    = 1'b1;
                            go_fast   = 1'b1;
                            nxt_phase = PH_CLK_OFF;
                        end
                        ST_SELECT:   nxt_step = high_cap ? ST_BUS_APP : ST_BLOCKLEN;
                        ST_BLOCKLEN: nxt_step = ST_BUS_APP;
                        ST_BUS_APP:  nxt_step = ST_BUS_WIDTH;
                        ST_BUS_WIDTH: end_ok = 1'b1;
                        default: begin end_fail = 1'b1; code = FAIL_IO; end
                    endcase
                end else if (cmd_timeout || poll_last) begin
                    unique case (step)
                        ST_IF_COND:              begin end_fail = 1'b1; code = FAIL_UNSUP; end
                        ST_LOOP_APP, ST_OP_COND: retry = 1'b1;
                        default:                 begin end_fail = 1'b1; code = FAIL_IO; end
                    endcase
                end
            end
            PH_BACKOFF: begin
                if (gap_last) begin
                    nxt_phase = PH_ISSUE;
                    nxt_step  = ST_LOOP_APP;
                end
            end
            default: nxt_phase = phase;
        endcase
        if (retry) begin
            if (att_last) begin
                end_fail = 1'b1;
                code     = FAIL_IO;
            end else begin
                nxt_phase = PH_BACKOFF;
            end
        end
        if (end_ok || end_fail) nxt_phase = PH_IDLE;
    end

    // State, result and card-information registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase           <= PH_IDLE;
            step            <= ST_GO_IDLE;
            fast_clk        <= 1'b0;
            busy            <= 1'b0;
            done            <= 1'b0;
            ok              <= 1'b0;
            err_code        <= FAIL_NONE;
            rca             <= '0;
            ocr             <= '0;
            high_cap        <= 1'b0;
            capacity_blocks <= '0;
        end else if (start) begin
            phase           <= clk_running ? PH_CLK_OFF : PH_CLK_ON;
            fast_clk        <= 1'b0;
            busy            <= 1'b1;
            done            <= 1'b0;
            ok              <= 1'b0;
            err_code        <= FAIL_NONE;
            rca             <= '0;
            ocr             <= '0;
            high_cap        <= 1'b0;
            capacity_blocks <= '0;
        end else begin
            phase <= nxt_phase;
            step  <= nxt_step;
            done  <= end_ok || end_fail;
            if (end_ok || end_fail) begin
                busy     <= 1'b0;
                ok       <= end_ok;
                err_code <= code;
            end
            if (go_fast) fast_clk <= 1'b1;
            if (ld_rca)  rca <= rsp_word[31:16];
            if (ld_ocr) begin
                ocr      <= rsp_word;
                high_cap <= rsp_word[30];
            end
            if (ld_cap)  capacity_blocks <= cap_calc;
        end
    end
endmodule

// File: rtl/sd_init_seq_chk.sv
// Property checker for sd_init_seq, attached by bind.
// Assumes it observes only the top-level ports.
module sd_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        cmd_valid,
    input logic [5:0]  cmd_index,
    input logic [31:0] cmd_arg,
    input logic        clk_stop,
    input logic        clk_set,
    input logic        clk_sel,
    input logic        busy,
    input logic        done,
    input logic        ok,
    input logic [1:0]  err_code,
    input logic        high_cap
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !clk_stop && !clk_set); // R1
    AST_IF_COND_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd8 |-> cmd_arg == 32'h1AA && !clk_sel); // R2
    AST_OP_COND_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd41 |-> cmd_arg == 32'h50FF8000); // R5
    AST_SELECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd7 |-> clk_sel); // R8
    AST_BLKLEN_SDSC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_index == 6'd16 |-> !high_cap && cmd_arg == 32'd512); // R9
    AST_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ok == (err_code == 2'd0)); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, clk_stop, clk_set})); // R13
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !start |=> $stable(cmd_index) && $stable(cmd_arg) && !cmd_valid); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R13
endmodule

bind sd_init_seq sd_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_valid (cmd_valid),
    .cmd_index (cmd_index),
    .cmd_arg   (cmd_arg),
    .clk_stop  (clk_stop),
    .clk_set   (clk_set),
    .clk_sel   (clk_sel),
    .busy      (busy),
    .done      (done),
    .ok        (ok),
    .err_code  (err_code),
    .high_cap  (high_cap)
);

// File: tb/sd_init_seq_bench.sv
// Directed bench: a behavioural card and clock unit answer the sequencer.
module sd_init_seq_bench;
    localparam int POLL  = 16;
    localparam int TRIES = 4;
    localparam int GAP   = 3;
    localparam int RLAT  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_valid, cmd_done, cmd_timeout;
    logic [5:0] cmd_index;
    logic [31:0] cmd_arg;
    logic [1:0] cmd_rsp_kind;
    logic [119:0] rsp_data;
    logic clk_running, clk_stable, clk_stop, clk_set, clk_sel;
    logic busy, done, ok, high_cap;
    logic [1:0] err_code;
    logic [15:0] rca;
    logic [31:0] ocr;
    logic [31:0] capacity_blocks;

    always #10 clk = ~clk;

    sd_init_seq #(.POLL_LIMIT(POLL), .ATTEMPT_LIMIT(TRIES), .RETRY_DELAY(GAP), .CAP_W(32)) u_sd_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rsp_kind(cmd_rsp_kind),
        .cmd_done(cmd_done), .cmd_timeout(cmd_timeout), .rsp_data(rsp_data),
        .clk_running(clk_running), .clk_stable(clk_stable), .clk_stop(clk_stop),
        .clk_set(clk_set), .clk_sel(clk_sel), .busy(busy), .done(done), .ok(ok),
        .err_code(err_code), .rca(rca), .ocr(ocr), .high_cap(high_cap),
        .capacity_blocks(capacity_blocks)
    );

    // Card model configuration
    bit m_c8_timeout, m_c8_bad, m_volt_bad, m_ccs;
    int m_busy_cnt, m_silent, m_csize, m_mult, m_bl;
    int op_base;
    logic [15:0] m_rca = 16'h4D21;

    int errors = 0, checks = 0;
    int cyc = 0;
    int nlog = 0, nck = 0, op_seen = 0;
    int log_idx[256], log_kind[256];
    logic [31:0] log_arg[256];
    int log_cyc[256], ck_ev[64];

    bit   pend = 0;
    int   pcnt = 0, pidx = 0;

    // Card responder: answers each command after RLAT cycles.
    always @(posedge clk) begin
        cmd_done    <= 1'b0;
        cmd_timeout <= 1'b0;
        if (!rst_n) begin
            pend <= 0;
            rsp_data <= '0;
        end else if (cmd_valid) begin
            pend <= 1; pcnt <= RLAT; pidx <= int'(cmd_index);
            log_idx[nlog % 256] <= int'(cmd_index);
            log_arg[nlog % 256] <= cmd_arg;
            log_kind[nlog % 256] <= int'(cmd_rsp_kind);
            log_cyc[nlog % 256] <= cyc;
            nlog <= nlog + 1;
        end else if (pend) begin
            if (pcnt > 1) pcnt <= pcnt - 1;
            else begin
                pend <= 0;
                if (pidx == m_silent) begin
                    // no answer at all
                end else if (pidx == 8) begin
                    if (m_c8_timeout) cmd_timeout <= 1'b1;
                    else begin
                        cmd_done <= 1'b1;
                        rsp_data <= {88'h0, (m_c8_bad ? 32'h1AB : 32'h1AA)};
                    end
                end else if (pidx == 41) begin
                    cmd_done <= 1'b1;
                    op_seen  <= op_seen + 1;
                    rsp_data <= {88'h0, ((op_seen - op_base) >= m_busy_cnt), m_ccs, 6'h0,
                                 (m_volt_bad ? 9'h1FE : 9'h1FF), 15'h0};
                end else if (pidx == 3) begin
                    cmd_done <= 1'b1;
                    rsp_data <= {88'h0, m_rca, 16'h0520};
                end else if (pidx == 9) begin
                    cmd_done <= 1'b1;
                    rsp_data <= csd_word(m_csize, m_mult, m_bl);
                end else begin
                    cmd_done <= 1'b1;
                    rsp_data <= '0;
                end
            end
        end
    end

    int ccnt = 0;
    // Clock unit model: settles three cycles after a set request.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            clk_running <= 0; clk_stable <= 0; ccnt <= 0;
        end else if (clk_stop) begin
            clk_running <= 0; clk_stable <= 0; ccnt <= 0;
            ck_ev[nck % 64] <= 0; nck <= nck + 1;
        end else if (clk_set) begin
            clk_running <= 1; clk_stable <= 0; ccnt <= 3;
            ck_ev[nck % 64] <= clk_sel ? 2 : 1; nck <= nck + 1;
        end else if (ccnt > 0) begin
            ccnt <= ccnt - 1;
            if (ccnt == 1) clk_stable <= 1;
        end
    end

    function automatic logic [119:0] csd_word(int cs, int mu, int bl);
        logic [119:0] w = '0;
        w[65:54] = cs[11:0];
        w[41:39] = mu[2:0];
        w[75:72] = bl[3:0];
        return w;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic setup(bit c8to, bit c8bad, bit vbad, int busyc, bit ccs, int silent,
                         int cs, int mu, int bl);
        m_c8_timeout = c8to; m_c8_bad = c8bad; m_volt_bad = vbad; m_busy_cnt = busyc;
        m_ccs = ccs; m_silent = silent; m_csize = cs; m_mult = mu; m_bl = bl;
        op_base = op_seen;
    endtask

    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(string req);
        bit seen = 0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(req, "done seen", seen, 1);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "ok", ok, 0);
        chk("R1", "cmd_valid", cmd_valid, 0);
        chk("R1", "err_code", err_code, 0);
    endtask

    task automatic t_sdsc();
        int b, c, k;
        int exp_i[15] = '{0, 8, 55, 41, 55, 41, 55, 41, 2, 3, 9, 7, 16, 55, 6};
        logic [31:0] ra;
        setup(0, 0, 0, 2, 0, -1, 100, 3, 9);
        b = nlog; c = nck;
        kick(); wait_done("R10");
        ra = {m_rca, 16'h0};
        chk("R10", "ok", ok, 1);
        chk("R10", "err", err_code, 0);
        chk("R8", "rca", rca, m_rca);
        chk("R10", "ocr", ocr, 32'h80FF8000);
        chk("R9", "high_cap", high_cap, 0);
        chk("R11", "capacity", capacity_blocks, ((64'd101) << (3 + 2 + 9)) >> 9);
        chk("R8", "cmd count", nlog - b, 15);
        for (int i = 0; i < 15; i++) chk("R8", "cmd order", log_idx[(b + i) % 256], exp_i[i]);
        chk("R2", "cmd0 arg", log_arg[b % 256], 0);
        chk("R2", "cmd0 kind", log_kind[b % 256], 0);
        chk("R2", "cmd8 arg", log_arg[(b + 1) % 256], 32'h1AA);
        chk("R5", "cmd55 arg", log_arg[(b + 2) % 256], 0);
        chk("R5", "acmd41 arg", log_arg[(b + 3) % 256], 32'h50FF8000);
        chk("R8", "cmd2 kind", log_kind[(b + 8) % 256], 2);
        chk("R8", "cmd9 arg", log_arg[(b + 10) % 256], ra);
        chk("R8", "cmd7 arg", log_arg[(b + 11) % 256], ra);
        chk("R9", "cmd16 arg", log_arg[(b + 12) % 256], 512);
        chk("R10", "cmd55 rca arg", log_arg[(b + 13) % 256], ra);
        chk("R10", "acmd6 arg", log_arg[(b + 14) % 256], 2);
        k = (log_cyc[(b + 4) % 256] - log_cyc[(b + 3) % 256]) -
            (log_cyc[(b + 3) % 256] - log_cyc[(b + 2) % 256]);
        chk("R6", "retry back-off", k, GAP);
        chk("R2", "clock events", nck - c, 3);
        chk("R2", "first set slow", ck_ev[c % 64], 1);
        chk("R8", "stop before fast", ck_ev[(c + 1) % 64], 0);
        chk("R8", "set fast", ck_ev[(c + 2) % 64], 2);
    endtask

    task automatic t_sdhc();
        int b, c;
        setup(0, 0, 0, 0, 1, -1, 4095, 7, 11);
        b = nlog; c = nck;
        kick(); wait_done("R9");
        chk("R9", "ok", ok, 1);
        chk("R9", "high_cap", high_cap, 1);
        chk("R9", "cmd count no cmd16", nlog - b, 10);
        chk("R9", "after cmd7", log_idx[(b + 8) % 256], 55);
        chk("R11", "capacity max", capacity_blocks, 32'd8388608);
        chk("R2", "stop when running", ck_ev[c % 64], 0);
        chk("R2", "then set slow", ck_ev[(c + 1) % 64], 1);
    endtask

    task automatic t_fail(string req, bit c8to, bit c8bad, bit vbad, int busyc, int silent, int code);
        setup(c8to, c8bad, vbad, busyc, 0, silent, 1, 0, 9);
        kick(); wait_done(req);
        chk(req, "ok", ok, 0);
        chk(req, "err_code", err_code, code);
        chk(req, "busy", busy, 0);
    endtask

    task automatic t_never_ready();
        int b, n41 = 0;
        b = nlog;
        t_fail("R6", 0, 0, 0, 1000, -1, 3);
        for (int i = b; i < nlog; i++) if (log_idx[i % 256] == 41) n41++;
        chk("R6", "attempts", n41, TRIES);
    endtask

    task automatic t_poll();
        int b;
        b = nlog;
        t_fail("R7", 0, 0, 0, 0, 2, 3);
        chk("R7", "stopped at cmd2", log_idx[(nlog - 1) % 256], 2);
        chk("R7", "cmd count", nlog - b, 5);
    endtask

    task automatic t_restart();
        int b, p = -1;
        bit hit = 0;
        setup(0, 0, 0, 0, 0, -1, 7, 1, 10);
        b = nlog;
        kick();
        for (int i = 0; i < 2000 && !hit; i++) begin
            @(negedge clk);
            if (nlog > b && log_idx[(nlog - 1) % 256] == 2) hit = 1;
        end
        kick();
        wait_done("R12");
        for (int i = b; i < nlog; i++) if (p < 0 && log_idx[i % 256] == 2) p = i;
        chk("R12", "cmd0 after restart", log_idx[(p + 1) % 256], 0);
        chk("R12", "ok after restart", ok, 1);
        chk("R11", "capacity", capacity_blocks, ((64'd8) << (1 + 2 + 10)) >> 9);
    endtask

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        setup(0, 0, 0, 0, 0, -1, 0, 0, 9);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sdsc();
        t_sdhc();
        t_fail("R3", 1, 0, 0, 0, -1, 1);
        t_fail("R4", 0, 1, 0, 0, -1, 2);
        t_fail("R5", 0, 0, 1, 0, -1, 2);
        t_never_ready();
        t_poll();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule